// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block sits in the decode stage of a five-stage, in-order integer pipeline. It turns a 6-bit opcode into a control word with three groups: one for the execute stage, one for the memory stage and one for the write-back stage. The word is carried forward with its instruction through three stage registers. Each register holds only the groups that the stages after it still need, so the stored word gets shorter as it moves down the pipe.

Hazard logic outside the block uses two inputs to control it. A bubble request puts an empty slot into the execute stage. The opcode held in decode is not lost, because the fetch side holds it. A flush request removes the wrong-path instructions that sit in decode and execute when a taken branch resolves in the memory stage. The branch itself carries on into write-back.

Top module: `pipe_ctl_decoder`

## Requirements
- R1: Opcode 000000 (register-register) gives, one cycle later, an execute group with destination-from-rd=1, ALU mode=10, immediate operand=0. It gives an empty memory group and a write-back group with register write=1 and result-from-memory=0.
- R2: Opcode 100011 (load) gives destination-from-rd=0, ALU mode=00, immediate operand=1, memory read=1, register write=1 and result-from-memory=1.
- R3: Opcode 101011 (store) gives ALU mode=00, immediate operand=1 and memory write=1. Every other signal is 0, including the two fields whose value does not matter for a store.
- R4: Opcode 000100 (branch-if-equal) gives ALU mode=01 and branch=1. Every other signal is 0.
- R5: Any opcode not listed in R1 to R4 gives an all-zero control word.
- R6: An opcode presented before clock edge n shows its execute group after edge n, its memory group after edge n+1 and its write-back group after edge n+2. Back-to-back opcodes do not disturb each other.
- R7: While the bubble request is high at an edge, the execute-stage register loads all zeros. The memory and write-back stages still advance normally at that edge.
- R8: While the flush request is high at an edge, both the execute-stage and memory-stage registers load all zeros. The write-back stage still takes the memory stage's write-back group at that edge.
- R9: A synchronous active-high reset clears all three stage registers, so every output is 0 after the reset edge.
- R10: The memory stage never has more than one of branch, memory read and memory write asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode of the instruction in decode |
| bubble_i | input | 1 | Insert an empty slot into the execute stage |
| flush_i | input | 1 | Kill the instructions in decode and execute |
| ex_dst_rd_o | output | 1 | Execute: write target comes from the rd field |
| ex_alu_op_o | output | 2 | Execute: ALU mode handed to the ALU-control sub-decoder |
| ex_alu_src_imm_o | output | 1 | Execute: second ALU operand is the immediate |
| mem_branch_o | output | 1 | Memory: instruction is a conditional branch |
| mem_read_o | output | 1 | Memory: data memory read |
| mem_write_o | output | 1 | Memory: data memory write |
| wb_reg_write_o | output | 1 | Write-back: register file write enable |
| wb_mem_to_reg_o | output | 1 | Write-back: write data comes from memory |

## Verification
Every stored control bit feeds an output directly. A corrupted execute-stage word therefore shows up at once on the execute outputs, and shows up again one and two cycles later on the memory and write-back outputs of the same instruction. A missed bubble or flush leaves stale nonzero control at the ports on the edge right after the request. The bench drives streams of opcodes with no gaps, so a group that slips by one stage, or gets mixed with its neighbour's group, gives a mismatch within three cycles.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int OPC_W = 6;

    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_RTYPE = 6'b000000;
    localparam opc_t OPC_LOAD  = 6'b100011;
    localparam opc_t OPC_STORE = 6'b101011;
    localparam opc_t OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10,
        ALU_RSVD  = 2'b11
    } alu_mode_e;

    typedef struct packed {
        logic      dst_rd;
        alu_mode_e alu_mode;
        logic      alu_imm;
    } ex_grp_t;

    typedef struct packed {
        logic is_branch;
        logic rd_en;
        logic wr_en;
    } mem_grp_t;

    typedef struct packed {
        logic reg_wr;
        logic from_mem;
    } wb_grp_t;

    typedef struct packed {
        ex_grp_t  ex;
        mem_grp_t mem;
        wb_grp_t  wb;
    } id_bundle_t;

    typedef struct packed {
        mem_grp_t mem;
        wb_grp_t  wb;
    } ex_bundle_t;

    localparam int ID_W = $bits(id_bundle_t);
    localparam int EX_W = $bits(ex_bundle_t);
    localparam int WB_W = $bits(wb_grp_t);

    function automatic id_bundle_t decode_opc(opc_t op);
        id_bundle_t b;
        b = '0;
        case (op)
            OPC_RTYPE: begin
                b.ex.dst_rd    = 1'b1;
                b.ex.alu_mode  = ALU_FUNCT;
                b.wb.reg_wr    = 1'b1;
            end
            OPC_LOAD: begin
                b.ex.alu_mode  = ALU_ADD;
                b.ex.alu_imm   = 1'b1;
                b.mem.rd_en    = 1'b1;
                b.wb.reg_wr    = 1'b1;
                b.wb.from_mem  = 1'b1;
            end
            OPC_STORE: begin
                b.ex.alu_mode  = ALU_ADD;
                b.ex.alu_imm   = 1'b1;
                b.mem.wr_en    = 1'b1;
            end
            OPC_BEQ: begin
                b.ex.alu_mode  = ALU_SUB;
                b.mem.is_branch = 1'b1;
            end
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
    import pctl_pkg::*;
(
    input  opc_t       opcode_i,
    output id_bundle_t bundle_o
);

    always_comb begin
        bundle_o = decode_opc(opcode_i);
    end

endmodule

// File: rtl/pctl_stage_reg.sv
module pctl_stage_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

    AST_STAGE_RESET: assert property (@(posedge clk) rst |=> (q_o == '0)); // R9

endmodule

// File: rtl/pipe_ctl_decoder.sv
module pipe_ctl_decoder
    import pctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode_i,
    input  logic       bubble_i,
    input  logic       flush_i,
    output logic       ex_dst_rd_o,
    output logic [1:0] ex_alu_op_o,
    output logic       ex_alu_src_imm_o,
    output logic       mem_branch_o,
    output logic       mem_read_o,
    output logic       mem_write_o,
    output logic       wb_reg_write_o,
    output logic       wb_mem_to_reg_o
);

    id_bundle_t dec_b;
    id_bundle_t idex_q;
    ex_bundle_t exmem_d;
    ex_bundle_t exmem_q;
    wb_grp_t    memwb_q;
    logic       idex_clr;

    pctl_decode u_dec (
        .opcode_i (opcode_i),
        .bundle_o (dec_b)
    );

    assign idex_clr = bubble_i | flush_i;

    pctl_stage_reg #(.W(ID_W)) u_idex (
        .clk   (clk),
        .rst   (rst),
        .clr_i (idex_clr),
        .d_i   (dec_b),
        .q_o   (idex_q)
    );

    always_comb begin
        exmem_d.mem = idex_q.mem;
        exmem_d.wb  = idex_q.wb;
    end

    pctl_stage_reg #(.W(EX_W)) u_exmem (
        .clk   (clk),
        .rst   (rst),
        .clr_i (flush_i),
        .d_i   (exmem_d),
        .q_o   (exmem_q)
    );

    pctl_stage_reg #(.W(WB_W)) u_memwb (
        .clk   (clk),
        .rst   (rst),
        .clr_i (1'b0),
        .d_i   (exmem_q.wb),
        .q_o   (memwb_q)
    );

    assign ex_dst_rd_o      = idex_q.ex.dst_rd;
    assign ex_alu_op_o      = idex_q.ex.alu_mode;
    assign ex_alu_src_imm_o = idex_q.ex.alu_imm;
    assign mem_branch_o     = exmem_q.mem.is_branch;
    assign mem_read_o       = exmem_q.mem.rd_en;
    assign mem_write_o      = exmem_q.mem.wr_en;
    assign wb_reg_write_o   = memwb_q.reg_wr;
    assign wb_mem_to_reg_o  = memwb_q.from_mem;

    AST_LOAD_WRITES_BACK: assert property (@(posedge clk) disable iff (rst)
        exmem_q.mem.rd_en |-> (exmem_q.wb.reg_wr && exmem_q.wb.from_mem)); // R2

    AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        exmem_q.mem.wr_en |-> (exmem_q.wb == '0)); // R3

    AST_BRANCH_EX_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (idex_q.ex.alu_mode == ALU_SUB) |-> (!idex_q.ex.alu_imm && !idex_q.ex.dst_rd)); // R4

    AST_BUBBLE_EMPTIES_EX: assert property (@(posedge clk) disable iff (rst)
        bubble_i |=> (idex_q == '0)); // R7

    AST_FLUSH_EMPTIES_EX_MEM: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> ((idex_q == '0) && (exmem_q == '0))); // R8

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_branch_o, mem_read_o, mem_write_o})); // R10

endmodule

// File: tb/sim_pipe_ctl_decoder.sv
`timescale 1ns/1ps
module sim_pipe_ctl_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode_i = 6'h3f;
    logic       bubble_i = 1'b0;
    logic       flush_i  = 1'b0;
    logic       ex_dst_rd_o;
    logic [1:0] ex_alu_op_o;
    logic       ex_alu_src_imm_o;
    logic       mem_branch_o, mem_read_o, mem_write_o;
    logic       wb_reg_write_o, wb_mem_to_reg_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pipe_ctl_decoder u0 (
        .clk              (clk),
        .rst              (rst),
        .opcode_i         (opcode_i),
        .bubble_i         (bubble_i),
        .flush_i          (flush_i),
        .ex_dst_rd_o      (ex_dst_rd_o),
        .ex_alu_op_o      (ex_alu_op_o),
        .ex_alu_src_imm_o (ex_alu_src_imm_o),
        .mem_branch_o     (mem_branch_o),
        .mem_read_o       (mem_read_o),
        .mem_write_o      (mem_write_o),
        .wb_reg_write_o   (wb_reg_write_o),
        .wb_mem_to_reg_o  (wb_mem_to_reg_o)
    );

    // entry: {opcode[5:0], dst, alu[1:0], imm, br, rd, wr, regwr, m2r}
    localparam logic [14:0] TBL [10] = '{
        {6'b000000, 9'b1_10_0_000_10},
        {6'b100011, 9'b0_00_1_010_11},
        {6'b101011, 9'b0_00_1_001_00},
        {6'b000100, 9'b0_01_0_100_00},
        {6'b111111, 9'b0_00_0_000_00},
        {6'b000000, 9'b1_10_0_000_10},
        {6'b000001, 9'b0_00_0_000_00},
        {6'b100011, 9'b0_00_1_010_11},
        {6'b000100, 9'b0_01_0_100_00},
        {6'b101011, 9'b0_00_1_001_00}
    };

    function automatic string req_of(logic [5:0] op);
        case (op)
            6'b000000: return "R1";
            6'b100011: return "R2";
            6'b101011: return "R3";
            6'b000100: return "R4";
            default:   return "R5";
        endcase
    endfunction

    function automatic logic [3:0] obs_ex();
        return {ex_dst_rd_o, ex_alu_op_o, ex_alu_src_imm_o};
    endfunction
    function automatic logic [3:0] obs_mem();
        return {1'b0, mem_branch_o, mem_read_o, mem_write_o};
    endfunction
    function automatic logic [3:0] obs_wb();
        return {2'b00, wb_reg_write_o, wb_mem_to_reg_o};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] e1, e2, e3;
        logic [5:0] o1, o2, o3;
        e1 = '0; e2 = '0; e3 = '0;
        o1 = 6'h3f; o2 = 6'h3f; o3 = 6'h3f;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        chk("R9 reset ex",  obs_ex(),  4'h0);
        chk("R9 reset mem", obs_mem(), 4'h0);
        chk("R9 reset wb",  obs_wb(),  4'h0);

        // table walk: back-to-back opcodes, stage timing
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            chk({req_of(o1), " R6 ex stage"},  obs_ex(),  e1[8:5]);
            chk({req_of(o2), " R6 mem stage"}, obs_mem(), {1'b0, e2[4:2]});
            chk({req_of(o3), " R6 wb stage"},  obs_wb(),  {2'b00, e3[1:0]});
            e3 = e2; e2 = e1; o3 = o2; o2 = o1;
            if (i < 10) begin
                e1 = TBL[i][8:0];
                o1 = TBL[i][14:9];
            end else begin
                e1 = '0;
                o1 = 6'h3f;
            end
            opcode_i = o1;
        end

        // R7: bubble behind a load
        @(negedge clk);
        opcode_i = 6'b100011;
        @(negedge clk);
        chk("R2 R7 load ex before bubble", obs_ex(), 4'b0001);
        opcode_i = 6'b000000;
        bubble_i = 1'b1;
        @(negedge clk);
        chk("R7 bubble empties ex", obs_ex(), 4'h0);
        chk("R7 load continues in mem", obs_mem(), 4'b0010);
        bubble_i = 1'b0;
        opcode_i = 6'h3f;
        @(negedge clk);
        chk("R7 load continues in wb", obs_wb(), 4'b0011);
        chk("R7 no stale mem after bubble", obs_mem(), 4'h0);

        // R8: flush with load in ex and R-type in decode
        repeat (2) @(negedge clk);
        opcode_i = 6'b100011;
        @(negedge clk);
        opcode_i = 6'b000000;
        @(negedge clk);
        chk("R1 R8 rtype in ex before flush", obs_ex(), 4'b1100);
        opcode_i = 6'b101011;
        flush_i  = 1'b1;
        @(negedge clk);
        chk("R8 flush empties ex",  obs_ex(),  4'h0);
        chk("R8 flush empties mem", obs_mem(), 4'h0);
        chk("R8 wb still advances", obs_wb(),  4'b0011);
        flush_i  = 1'b0;
        opcode_i = 6'h3f;
        @(negedge clk);
        chk("R8 killed rtype leaves no wb", obs_wb(), 4'h0);

        // R9: reset mid-stream
        opcode_i = 6'b100011;
        @(negedge clk);
        opcode_i = 6'b101011;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 midstream ex",  obs_ex(),  4'h0);
        chk("R9 midstream mem", obs_mem(), 4'h0);
        chk("R9 midstream wb",  obs_wb(),  4'h0);
        rst = 1'b0;
        opcode_i = 6'h3f;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule